// File: doc/BRIEF.md
# Halt and wake-up power controller

This block governs the deepest low-power state of a small microcontroller core. While the core runs, the controller keeps the oscillator, the peripheral clock and the CPU clock enabled. It also produces a master CPU clock enable, a one-cycle tick at one third of the oscillator rate. When instruction decode reports a halt instruction, the controller turns all three enables off. At the same moment it clears the interrupt-mask bit, so that any wake event is accepted.

A wake event can be any external interrupt line, a USB end-of-suspend (resume) event, or a reset request. On a wake event the oscillator is switched on at once. The CPU and peripheral clocks stay gated until a fixed number of CPU clock ticks has passed, so that the oscillator can settle. After that delay the controller issues a one-cycle indication to the core: either service the interrupt or fetch the reset vector, depending on what caused the wake. A reset request has priority over an interrupt at every point in this sequence. The interrupt-mask bit is set while the interrupt is serviced and is cleared when the core restores its flags on return from interrupt.

`clk_i` models the oscillator output. The divider and the stabilization counter only advance while the oscillator enable is high.

Top module: `halt_wake_ctrl`

## Requirements
- R1: During and directly after `rst_ni` low, the block is in the running state: `osc_en_o`, `periph_clk_en_o` and `cpu_clk_en_o` are 1, `imask_o` is 1, and `svc_irq_o` and `fetch_rst_o` are 0.
- R2: While running, `cpu_tick_o` is a one-cycle pulse every third `clk_i` cycle (10 pulses in 30 cycles, never two in a row). It is 0 whenever `cpu_clk_en_o` is 0.
- R3: The halt state is entered only when `halt_i` is high in the running state. `halt_i` during the stabilization delay is ignored. Interrupt and resume inputs while running leave all outputs unchanged.
- R4: The edge that enters halt also clears `imask_o` to 0.
- R5: In halt, `osc_en_o`, `periph_clk_en_o` and `cpu_clk_en_o` are all 0.
- R6: In halt, a 1 on any bit of `ext_irq_i`, on `usb_resume_i` or on `ext_rst_i` starts the delay. From the next cycle `osc_en_o` is 1 while both clock enables stay 0.
- R7: The CPU and peripheral clock enables rise together exactly 3*STAB_CYCLES `clk_i` cycles after `osc_en_o` rises (12288 cycles with the default STAB_CYCLES of 4096). Neither is ever 1 while `osc_en_o` is 0.
- R8: In the first cycle of running after the delay, the block pulses exactly one output for one cycle: `svc_irq_o` for an interrupt or resume wake, `fetch_rst_o` for a reset wake.
- R9: `imask_o` is 1 together with `svc_irq_o` and stays 1 until `irq_ret_i` is high while running, which clears it on the next edge.
- R10: `ext_rst_i` during the delay changes the outcome to `fetch_rst_o` without restarting the delay.
- R11: `ext_rst_i` while running gives a `fetch_rst_o` pulse and `imask_o` = 1 on the next cycle, with the clocks left on. It takes priority over a `halt_i` in the same cycle.
- R12: The divider is held at zero while the oscillator is off. The first `cpu_tick_o` after a wake appears in the third cycle of running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator reference clock |
| rst_ni | input | 1 | Active-low asynchronous power-on reset |
| halt_i | input | 1 | Halt instruction executed by the core |
| ext_irq_i | input | N_IRQ | External interrupt lines |
| usb_resume_i | input | 1 | USB end-of-suspend event |
| ext_rst_i | input | 1 | Reset request (wake source, highest priority) |
| irq_ret_i | input | 1 | Flags restored on return from interrupt |
| osc_en_o | output | 1 | Oscillator enable |
| periph_clk_en_o | output | 1 | Peripheral clock enable |
| cpu_clk_en_o | output | 1 | CPU clock enable |
| cpu_tick_o | output | 1 | Master CPU clock enable, oscillator / 3 |
| imask_o | output | 1 | Interrupt-mask bit |
| svc_irq_o | output | 1 | One-cycle pulse: service the waking interrupt |
| fetch_rst_o | output | 1 | One-cycle pulse: fetch the reset vector |

## Verification
Two events can land in the same cycle: an interrupt wake that is already in its stabilization delay, and a reset request arriving before the delay ends. The bench starts an interrupt wake and pulses `ext_rst_i` partway through the delay. It then expects the clock enables to rise at the same 12288-cycle mark as an undisturbed wake, with `fetch_rst_o` rather than `svc_irq_o`. A second case drives `ext_rst_i` and `halt_i` together while running and expects a reset-vector pulse with the clocks still on.

// File: rtl/halt_pkg.sv
package halt_pkg;
  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_HALT = 2'd1,
    ST_STAB = 2'd2
  } pwr_state_e;

  typedef enum logic {
    SRC_IRQ = 1'b0,
    SRC_RST = 1'b1
  } wake_src_e;
endpackage

// File: rtl/hw_div3.sv
module hw_div3 #(
  parameter int DIV = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic tick_o
);
  localparam int W = $clog2(DIV);
  localparam logic [W-1:0] LAST = W'(DIV - 1);

  logic [W-1:0] cnt_q;

  // held at zero while the oscillator is off
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (!en_i)       cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                  cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = en_i && (cnt_q == LAST);
endmodule

// File: rtl/hw_stab_cnt.sv
module hw_stab_cnt #(
  parameter int CYCLES = 4096
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic tick_i,
  output logic done_o
);
  localparam int W = $clog2(CYCLES);
  localparam logic [W-1:0] LAST = W'(CYCLES - 1);

  logic [W-1:0] cnt_q;

  assign done_o = run_i && tick_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (!run_i) cnt_q <= '0;
    else if (tick_i) cnt_q <= done_o ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/hw_halt_fsm.sv
module hw_halt_fsm
  import halt_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       halt_i,
  input  logic       wake_irq_i,
  input  logic       wake_rst_i,
  input  logic       irq_ret_i,
  input  logic       stab_done_i,
  output pwr_state_e state_o,
  output logic       imask_o,
  output logic       svc_irq_o,
  output logic       fetch_rst_o
);
  pwr_state_e state_q, state_d;
  wake_src_e  src_q, src_d;
  logic       imask_q, imask_d;
  logic       svc_d, fetch_d;

  always_comb begin
    state_d = state_q;
    src_d   = src_q;
    imask_d = imask_q;
    svc_d   = 1'b0;
    fetch_d = 1'b0;
    unique case (state_q)
      ST_RUN: begin
        if (wake_rst_i) begin
          fetch_d = 1'b1;
          imask_d = 1'b1;
        end else if (halt_i) begin
          state_d = ST_HALT;
          imask_d = 1'b0;
        end else if (irq_ret_i) begin
          imask_d = 1'b0;
        end
      end
      ST_HALT: begin
        if (wake_rst_i) begin
          state_d = ST_STAB;
          src_d   = SRC_RST;
        end else if (wake_irq_i) begin
          state_d = ST_STAB;
          src_d   = SRC_IRQ;
        end
      end
      ST_STAB: begin
        // reset overrides a pending interrupt wake, delay keeps running
        if (wake_rst_i) src_d = SRC_RST;
        if (stab_done_i) begin
          state_d = ST_RUN;
          imask_d = 1'b1;
          svc_d   = (src_d == SRC_IRQ);
          fetch_d = (src_d == SRC_RST);
        end
      end
      default: state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_RUN;
      src_q       <= SRC_IRQ;
      imask_q     <= 1'b1;
      svc_irq_o   <= 1'b0;
      fetch_rst_o <= 1'b0;
    end else begin
      state_q     <= state_d;
      src_q       <= src_d;
      imask_q     <= imask_d;
      svc_irq_o   <= svc_d;
      fetch_rst_o <= fetch_d;
    end
  end

  assign state_o = state_q;
  assign imask_o = imask_q;
endmodule

// File: rtl/halt_wake_ctrl.sv
module halt_wake_ctrl
  import halt_pkg::*;
#(
  parameter int N_IRQ      = 4,
  parameter int CLK_DIV    = 3,
  parameter int STAB_CYCLES = 4096
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             halt_i,
  input  logic [N_IRQ-1:0] ext_irq_i,
  input  logic             usb_resume_i,
  input  logic             ext_rst_i,
  input  logic             irq_ret_i,
  output logic             osc_en_o,
  output logic             periph_clk_en_o,
  output logic             cpu_clk_en_o,
  output logic             cpu_tick_o,
  output logic             imask_o,
  output logic             svc_irq_o,
  output logic             fetch_rst_o
);
  pwr_state_e state;
  logic       wake_irq, div_tick, stab_done, running;

  assign wake_irq = (|ext_irq_i) | usb_resume_i;
  assign running  = (state == ST_RUN);

  hw_div3 #(.DIV(CLK_DIV)) i_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (osc_en_o),
    .tick_o (div_tick)
  );

  hw_stab_cnt #(.CYCLES(STAB_CYCLES)) i_stab (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (state == ST_STAB),
    .tick_i (div_tick),
    .done_o (stab_done)
  );

  hw_halt_fsm i_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .halt_i      (halt_i),
    .wake_irq_i  (wake_irq),
    .wake_rst_i  (ext_rst_i),
    .irq_ret_i   (irq_ret_i),
    .stab_done_i (stab_done),
    .state_o     (state),
    .imask_o     (imask_o),
    .svc_irq_o   (svc_irq_o),
    .fetch_rst_o (fetch_rst_o)
  );

  assign osc_en_o        = (state != ST_HALT);
  assign cpu_clk_en_o    = running;
  assign periph_clk_en_o = running;
  assign cpu_tick_o      = div_tick && running;
endmodule

// File: rtl/halt_wake_chk.sv
module halt_wake_chk #(
  parameter int N_IRQ = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             halt_i,
  input logic [N_IRQ-1:0] ext_irq_i,
  input logic             usb_resume_i,
  input logic             ext_rst_i,
  input logic             irq_ret_i,
  input logic             osc_en_o,
  input logic             periph_clk_en_o,
  input logic             cpu_clk_en_o,
  input logic             cpu_tick_o,
  input logic             imask_o,
  input logic             svc_irq_o,
  input logic             fetch_rst_o
);
  AST_TICK_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_tick_o |-> cpu_clk_en_o); // R2
  AST_TICK_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_tick_o |=> !cpu_tick_o); // R2
  AST_HALT_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_clk_en_o && halt_i && !ext_rst_i) |=> (!osc_en_o && !imask_o)); // R4
  AST_STAB_HALT_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (osc_en_o && !cpu_clk_en_o && halt_i) |=> osc_en_o); // R3
  AST_HALT_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !osc_en_o |-> (!cpu_clk_en_o && !periph_clk_en_o)); // R5
  AST_WAKE_OSC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!osc_en_o && (ext_rst_i || (|ext_irq_i) || usb_resume_i)) |=> (osc_en_o && !cpu_clk_en_o)); // R6
  AST_CLK_PAIR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    periph_clk_en_o == cpu_clk_en_o); // R7
  AST_PULSE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(svc_irq_o && fetch_rst_o)); // R8
  AST_SVC_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    svc_irq_o |-> (imask_o && cpu_clk_en_o)); // R9
  AST_RETI_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_clk_en_o && irq_ret_i && !halt_i && !ext_rst_i) |=> !imask_o); // R9
  AST_RUN_RESET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_clk_en_o && ext_rst_i) |=> (fetch_rst_o && imask_o && cpu_clk_en_o)); // R11
endmodule

bind halt_wake_ctrl halt_wake_chk #(.N_IRQ(N_IRQ)) i_halt_wake_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .halt_i          (halt_i),
  .ext_irq_i       (ext_irq_i),
  .usb_resume_i    (usb_resume_i),
  .ext_rst_i       (ext_rst_i),
  .irq_ret_i       (irq_ret_i),
  .osc_en_o        (osc_en_o),
  .periph_clk_en_o (periph_clk_en_o),
  .cpu_clk_en_o    (cpu_clk_en_o),
  .cpu_tick_o      (cpu_tick_o),
  .imask_o         (imask_o),
  .svc_irq_o       (svc_irq_o),
  .fetch_rst_o     (fetch_rst_o)
);

// File: tb/test_halt_wake_ctrl.sv
`timescale 1ns/1ps
module test_halt_wake_ctrl;
  localparam int N_IRQ = 4;
  localparam int STAB  = 4096;
  localparam int DELAY = 3 * STAB;

  // row: kind[3:2] (0 irq line, 1 usb resume, 2 reset), mid-delay reset[1], expect fetch[0]
  localparam logic [3:0] WAKE_TBL [4] = '{4'b00_0_0, 4'b01_0_0, 4'b10_0_1, 4'b00_1_1};

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic             halt_i = 1'b0;
  logic [N_IRQ-1:0] ext_irq_i = '0;
  logic             usb_resume_i = 1'b0;
  logic             ext_rst_i = 1'b0;
  logic             irq_ret_i = 1'b0;
  logic osc_en_o, periph_clk_en_o, cpu_clk_en_o, cpu_tick_o, imask_o, svc_irq_o, fetch_rst_o;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  halt_wake_ctrl #(.N_IRQ(N_IRQ)) i_halt_wake_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .halt_i(halt_i), .ext_irq_i(ext_irq_i),
    .usb_resume_i(usb_resume_i), .ext_rst_i(ext_rst_i), .irq_ret_i(irq_ret_i),
    .osc_en_o(osc_en_o), .periph_clk_en_o(periph_clk_en_o), .cpu_clk_en_o(cpu_clk_en_o),
    .cpu_tick_o(cpu_tick_o), .imask_o(imask_o), .svc_irq_o(svc_irq_o), .fetch_rst_o(fetch_rst_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic run_wake(input logic [3:0] row);
    int n;
    logic exp_fetch;
    exp_fetch = row[0];
    halt_i = 1'b1;
    @(negedge clk);
    halt_i = 1'b0;
    chk("R5 osc off in halt", osc_en_o, 0);
    chk("R5 cpu/periph off in halt", cpu_clk_en_o | periph_clk_en_o, 0);
    chk("R4 imask cleared on halt", imask_o, 0);
    repeat (5) @(negedge clk);
    chk("R5 still halted", osc_en_o, 0);
    unique case (row[3:2])
      2'd0:    ext_irq_i[2] = 1'b1;
      2'd1:    usb_resume_i = 1'b1;
      default: ext_rst_i    = 1'b1;
    endcase
    @(negedge clk);
    ext_irq_i = '0; usb_resume_i = 1'b0; ext_rst_i = 1'b0;
    chk("R6 osc on after wake", osc_en_o, 1);
    chk("R6 clocks gated after wake", cpu_clk_en_o | periph_clk_en_o, 0);
    n = 0;
    while (!cpu_clk_en_o && n < DELAY + 100) begin
      halt_i    = (n == 50);                 // R3 halt ignored during delay
      ext_rst_i = row[1] && (n == 100);      // R10 reset during delay
      @(negedge clk);
      n++;
    end
    halt_i = 1'b0; ext_rst_i = 1'b0;
    chk("R7 delay length", n, DELAY);
    chk("R7 periph enable with cpu", periph_clk_en_o, 1);
    chk(row[1] ? "R10 mid-delay reset gives fetch" : "R8 fetch pulse", fetch_rst_o, exp_fetch);
    chk("R8 service pulse", svc_irq_o, !exp_fetch);
    chk("R9 imask set on wake", imask_o, 1);
    chk("R12 no tick in first run cycle", cpu_tick_o, 0);
    @(negedge clk);
    chk("R8 pulses last one cycle", svc_irq_o | fetch_rst_o, 0);
    chk("R12 no tick in second run cycle", cpu_tick_o, 0);
    @(negedge clk);
    chk("R12 first tick in third run cycle", cpu_tick_o, 1);
    irq_ret_i = 1'b1;
    @(negedge clk);
    irq_ret_i = 1'b0;
    chk("R9 return clears imask", imask_o, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int ticks;
    logic prev;
    repeat (3) @(negedge clk);
    chk("R1 osc during reset", osc_en_o, 1);
    chk("R1 imask during reset", imask_o, 1);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1 clocks after reset", cpu_clk_en_o & periph_clk_en_o & osc_en_o, 1);
    chk("R1 pulses idle after reset", svc_irq_o | fetch_rst_o, 0);

    ticks = 0; prev = 1'b0;
    for (int i = 0; i < 30; i++) begin
      if (cpu_tick_o) ticks++;
      if (prev && cpu_tick_o) chk("R2 ticks not adjacent", 1, 0);
      prev = cpu_tick_o;
      @(negedge clk);
    end
    chk("R2 ticks in 30 cycles", ticks, 10);

    ext_irq_i = 4'b1001; usb_resume_i = 1'b1;
    @(negedge clk);
    ext_irq_i = '0; usb_resume_i = 1'b0;
    @(negedge clk);
    chk("R3 wake inputs ignored while running", {cpu_clk_en_o, osc_en_o, imask_o, svc_irq_o, fetch_rst_o}, 5'b11100);

    ext_rst_i = 1'b1; halt_i = 1'b1;
    @(negedge clk);
    ext_rst_i = 1'b0; halt_i = 1'b0;
    chk("R11 reset wins over halt", {cpu_clk_en_o, osc_en_o, fetch_rst_o, imask_o}, 4'b1111);
    @(negedge clk);
    chk("R11 fetch pulse one cycle", fetch_rst_o, 0);

    for (int r = 0; r < 4; r++) run_wake(WAKE_TBL[r]);

    finish_run();
  end
endmodule